// File: doc/BRIEF.md
# Flash Read Wait-State Controller

This block sits between a processor's fetch and data-read port and a slow non-volatile memory array. A small control word sets how many wait states are added to each access: 0, 1, 2 or 3. The block counts off those cycles before it returns the read word to the core. The memory side is a plain address and data port with a fixed access time. The block marks the first cycle of each access with a strobe and samples the data in the last cycle of the access.

Two features reduce memory traffic. The first is an optional sequential prefetch. After a demand read, the next word is fetched into a one-entry buffer, and a later request that hits this buffer is answered with no wait states. The second is an optional hold on conditional-branch target fetches. When the hold is enabled, a request marked as a conditional-branch target waits until the core resolves the branch. A not-taken branch is then answered with a "dropped" response and no memory access at all. A third control bit lets a per-request cacheable attribute decide whether a request may use the prefetch buffer.

Top module: `flash_ws_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00000011, meaning one wait state with prefetch enabled and the other modes off. After reset, `rsp_ready` is 0 and `req_ready` is 1.
- R2: Control word layout:
  - bits [1:0] are the wait-state count.
  - bit 4 enables prefetch.
  - bit 5 enables the branch-target hold.
  - bit 6 enables the cacheable-attribute mode.
  - every other bit reads 0 and ignores writes.
  - For example, writing 0xFFFFFFFF reads back 0x00000073.
- R3: A pulse on `hw_ws_we` loads `hw_ws_val` into bits [1:0]. When it coincides with a register write, the hardware value wins for that field.
- R4: A request that misses the buffer starts a memory access: `mem_req` is high in its first cycle. `rsp_ready` rises N+1 rising edges after the acceptance edge, where N is the wait-state count. `rsp_data` then equals the memory word at `req_addr`.
- R5: A change to the wait-state count does not alter the latency of an access already in progress. It applies from the next accepted request.
- R6: With prefetch enabled, the block fetches address+4 after a completed demand read that is neither a branch target nor non-cacheable, and also after a buffer hit. While it does so, `req_ready` is low. A request to the buffered address gets `rsp_ready` in the cycle right after the acceptance edge, with no memory access. That response carries the buffered word.
- R7: With prefetch disabled, no prefetch is started and each request costs one memory access.
- R8: A branch-target request, or any request that misses the buffer, empties the buffer. A later request to the old buffered address then goes to memory.
- R9: With the hold disabled, a branch-target request is fetched at once with normal latency and `rsp_drop`=0. In that mode `br_resolve` has no effect.
- R10: With the hold enabled, a branch-target request makes no memory access until `br_resolve`.
  - If taken: the fetch starts at the resolve edge and `rsp_ready` rises N+1 edges later.
  - If not taken: `rsp_ready` and `rsp_drop` are high in the cycle right after the resolve edge, and no memory access is made.
- R11: Over the same stream of branches, the hold mode makes exactly one memory access fewer for each not-taken branch.
- R12: With bit 6 set, a request with `req_cach`=0 never hits the buffer and starts no prefetch. With bit 6 clear, `req_cach` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| hw_ws_we | input | 1 | Hardware update strobe for the wait-state field |
| hw_ws_val | input | 2 | Hardware wait-state value |
| req_valid | input | 1 | Core request valid, held until accepted |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | AW | Request byte address |
| req_cbr | input | 1 | Request is a conditional-branch target fetch |
| req_cach | input | 1 | Request cacheable attribute |
| br_resolve | input | 1 | Branch outcome known this cycle |
| br_taken | input | 1 | Resolved branch was taken |
| rsp_ready | output | 1 | Response valid pulse |
| rsp_drop | output | 1 | Response carries no data (not-taken branch) |
| rsp_data | output | DW | Response read data |
| mem_req | output | 1 | First cycle of a memory access |
| mem_addr | output | AW | Memory address, stable through the access |
| mem_rdata | input | DW | Memory read data |

## Verification
A bad wait counter or a bad latched wait count shows up on the first response after it. `rsp_ready` arrives one or more edges off the expected N+1, so the fault is visible within four cycles of acceptance. A corrupt buffer tag or valid bit shows on the next request to the prefetched address. That request gets either a zero-latency answer with wrong data, or a memory strobe where none was due. A wrong state in the branch hold shows as strobes on `mem_req` before `br_resolve`, or as a wrong `rsp_drop` in the cycle after it. Each of these is seen either at once or as a miscount of memory strobes over the scripted branch stream.

// File: rtl/flash_ws_pkg.sv
// Shared constants and types for the flash wait-state controller.
// Assumes a 32-bit control word; field positions are fixed here only.
package flash_ws_pkg;
    localparam int CFG_W    = 32;
    localparam int WS_W     = 2;
    localparam int WS_LSB   = 0;
    localparam int PF_BIT   = 4;
    localparam int HOLD_BIT = 5;
    localparam int PROT_BIT = 6;
    localparam logic [CFG_W-1:0] CFG_MASK  = 32'h0000_0073;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0011;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_DEMAND = 2'd1,
        SQ_HOLD   = 2'd2,
        SQ_PREF   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/fws_cfg_reg.sv
// Control word for the wait-state controller.
// Holds a masked image of the word; reserved bits stay 0. The hardware
// update of the wait-state field overrides a same-cycle software write.
module fws_cfg_reg
    import flash_ws_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             hw_we,
    input  logic [WS_W-1:0]  hw_ws,
    output logic [CFG_W-1:0] rd_data,
    output logic [WS_W-1:0]  ws,
    output logic             pf_en,
    output logic             hold_en,
    output logic             prot_en
);
    logic [CFG_W-1:0] cfg_q;

    // Register image: software write first, hardware field update last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            if (wr_en) begin
                cfg_q <= wr_data & CFG_MASK;
            end
            if (hw_we) begin
                cfg_q[WS_LSB +: WS_W] <= hw_ws;
            end
        end
    end

    // Field decode and read-back.
    always_comb begin
        rd_data = cfg_q;
        ws      = cfg_q[WS_LSB +: WS_W];
        pf_en   = cfg_q[PF_BIT];
        hold_en = cfg_q[HOLD_BIT];
        prot_en = cfg_q[PROT_BIT];
    end

    assert_hw_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_we |=> (ws == $past(hw_ws)));
endmodule

// File: rtl/fws_wait_timer.sv
// Down-counter for access wait states.
// A load sets the count; it then falls by one per cycle to zero.
// done is high while the count is zero (last cycle of an access).
module fws_wait_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Count register: load wins, else decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Completion flag.
    assign done = (cnt == '0);

    assert_tick_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fws_pf_buf.sv
// One-entry prefetch buffer: a tag, a valid flag and a data word.
// Assumes flush and fill are never asserted in the same cycle;
// if they were, fill would win.
module fws_pf_buf #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          fill,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    input  logic [AW-1:0] lookup_addr,
    output logic          hit,
    output logic [DW-1:0] rd_data
);
    logic          valid;
    logic [AW-1:0] tag;
    logic [DW-1:0] word;

    // Entry storage and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            tag   <= '0;
            word  <= '0;
        end else if (fill) begin
            valid <= 1'b1;
            tag   <= fill_addr;
            word  <= fill_data;
        end else if (flush) begin
            valid <= 1'b0;
        end
    end

    // Tag compare.
    assign hit     = valid && (tag == lookup_addr);
    assign rd_data = word;

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !fill) |=> !valid);
endmodule

// File: rtl/fws_seq.sv
// Access sequencer. It accepts one core request at a time and chooses
// between a buffer hit, a memory demand read and a held branch target.
// After a demand read or hit it runs the sequential prefetch. It assumes
// the memory array returns valid data by the last cycle of the access.
module fws_seq
    import flash_ws_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WS_W-1:0] ws,
    input  logic            pf_en,
    input  logic            hold_en,
    input  logic            prot_en,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_cbr,
    input  logic            req_cach,
    input  logic            br_resolve,
    input  logic            br_taken,
    output logic            rsp_ready,
    output logic            rsp_drop,
    output logic [DW-1:0]   rsp_data,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic            tmr_load,
    output logic [WS_W-1:0] tmr_val,
    input  logic            tmr_done,
    output logic            buf_flush,
    output logic            buf_fill,
    output logic [AW-1:0]   buf_fill_addr,
    output logic [DW-1:0]   buf_fill_data,
    input  logic            buf_hit,
    input  logic [DW-1:0]   buf_data
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    seq_state_t      state;
    logic [AW-1:0]   cur_addr;
    logic [WS_W-1:0] ws_q;
    logic            cur_pf;
    logic            accept, cacheable, hit_ok, held;
    logic            start_dem, start_res, start_pf;

    // Request classification for the current cycle.
    always_comb begin
        req_ready = (state == SQ_IDLE);
        accept    = req_valid && req_ready;
        cacheable = !prot_en || req_cach;
        hit_ok    = buf_hit && !req_cbr && cacheable;
        held      = req_cbr && hold_en;
        start_dem = accept && !hit_ok && !held;
        start_res = (state == SQ_HOLD) && br_resolve && br_taken;
        start_pf  = ((state == SQ_DEMAND) && tmr_done && cur_pf) ||
                    (accept && hit_ok && pf_en);
    end

    // Timer and buffer control.
    always_comb begin
        tmr_load      = start_dem || start_res || start_pf;
        tmr_val       = start_res ? ws_q : ws;
        buf_flush     = accept && !hit_ok;
        buf_fill      = (state == SQ_PREF) && tmr_done;
        buf_fill_addr = cur_addr;
        buf_fill_data = mem_rdata;
        mem_addr      = cur_addr;
    end

    // Main sequencer: state, access address and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            cur_addr  <= '0;
            ws_q      <= '0;
            cur_pf    <= 1'b0;
            mem_req   <= 1'b0;
            rsp_ready <= 1'b0;
            rsp_drop  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            mem_req   <= 1'b0;
            rsp_ready <= 1'b0;
            rsp_drop  <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        if (hit_ok) begin
                            rsp_ready <= 1'b1;
                            rsp_data  <= buf_data;
                            if (pf_en) begin
                                state    <= SQ_PREF;
                                cur_addr <= req_addr + STEP;
                                mem_req  <= 1'b1;
                            end
                        end else if (held) begin
                            state    <= SQ_HOLD;
                            cur_addr <= req_addr;
                            ws_q     <= ws;
                        end else begin
                            state    <= SQ_DEMAND;
                            cur_addr <= req_addr;
                            mem_req  <= 1'b1;
                            cur_pf   <= pf_en && cacheable && !req_cbr;
                        end
                    end
                end
                SQ_DEMAND: begin
                    if (tmr_done) begin
                        rsp_ready <= 1'b1;
                        rsp_data  <= mem_rdata;
                        if (cur_pf) begin
                            state    <= SQ_PREF;
                            cur_addr <= cur_addr + STEP;
                            mem_req  <= 1'b1;
                        end else begin
                            state <= SQ_IDLE;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (br_resolve) begin
                        if (br_taken) begin
                            state   <= SQ_DEMAND;
                            mem_req <= 1'b1;
                            cur_pf  <= 1'b0;
                        end else begin
                            rsp_ready <= 1'b1;
                            rsp_drop  <= 1'b1;
                            state     <= SQ_IDLE;
                        end
                    end
                end
                SQ_PREF: begin
                    if (tmr_done) begin
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assert_hold_no_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_HOLD) |-> !mem_req);

    assert_drop_after_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_drop |-> ($past(state) == SQ_HOLD));

    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
endmodule

// File: rtl/flash_ws_ctrl.sv
// Top level of the flash read wait-state controller. It joins the control
// word, the wait timer, the prefetch buffer and the access sequencer.
// Assumes a memory array with a fixed access time given by the wait states.
module flash_ws_ctrl
    import flash_ws_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          hw_ws_we,
    input  logic [1:0]    hw_ws_val,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_cbr,
    input  logic          req_cach,
    input  logic          br_resolve,
    input  logic          br_taken,
    output logic          rsp_ready,
    output logic          rsp_drop,
    output logic [DW-1:0] rsp_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata
);
    logic [WS_W-1:0] ws, tmr_val;
    logic            pf_en, hold_en, prot_en;
    logic            tmr_load, tmr_done;
    logic            buf_flush, buf_fill, buf_hit;
    logic [AW-1:0]   buf_fill_addr;
    logic [DW-1:0]   buf_fill_data, buf_data;

    fws_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_data(cfg_wdata),
        .hw_we(hw_ws_we), .hw_ws(hw_ws_val), .rd_data(cfg_rdata),
        .ws(ws), .pf_en(pf_en), .hold_en(hold_en), .prot_en(prot_en)
    );

    fws_wait_timer #(.W(WS_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .done(tmr_done)
    );

    fws_pf_buf #(.AW(AW), .DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .flush(buf_flush), .fill(buf_fill),
        .fill_addr(buf_fill_addr), .fill_data(buf_fill_data),
        .lookup_addr(req_addr), .hit(buf_hit), .rd_data(buf_data)
    );

    fws_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ws(ws), .pf_en(pf_en), .hold_en(hold_en),
        .prot_en(prot_en), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cbr(req_cbr), .req_cach(req_cach),
        .br_resolve(br_resolve), .br_taken(br_taken),
        .rsp_ready(rsp_ready), .rsp_drop(rsp_drop), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_done(tmr_done),
        .buf_flush(buf_flush), .buf_fill(buf_fill),
        .buf_fill_addr(buf_fill_addr), .buf_fill_data(buf_fill_data),
        .buf_hit(buf_hit), .buf_data(buf_data)
    );
endmodule

// File: tb/flash_ws_ctrl_test.sv
`timescale 1ns/1ps
module flash_ws_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        hw_ws_we = 1'b0;
    logic [1:0]  hw_ws_val = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_cbr = 1'b0;
    logic        req_cach = 1'b1;
    logic        br_resolve = 1'b0;
    logic        br_taken = 1'b0;
    logic        rsp_ready, rsp_drop, mem_req;
    logic [31:0] rsp_data, mem_addr, mem_rdata;

    int errors = 0;
    int checks = 0;
    int mem_cnt = 0;

    always #2.5 clk = ~clk;

    // Memory model: fixed-time array whose word is a function of address.
    assign mem_rdata = mem_addr ^ 32'h5A5A_0000;

    always @(posedge clk) if (rst_n && mem_req) mem_cnt <= mem_cnt + 1;

    flash_ws_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .hw_ws_we(hw_ws_we), .hw_ws_val(hw_ws_val),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_cbr(req_cbr), .req_cach(req_cach), .br_resolve(br_resolve),
        .br_taken(br_taken), .rsp_ready(rsp_ready), .rsp_drop(rsp_drop),
        .rsp_data(rsp_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    // Table rows: {ws[1:0], pf, addr[15:0], latency[3:0], accesses[3:0]}
    localparam int NROW = 9;
    localparam logic [26:0] ROWS [NROW] = '{
        {2'd2, 1'b1, 16'h0100, 4'd3, 4'd2},
        {2'd2, 1'b1, 16'h0104, 4'd0, 4'd1},
        {2'd0, 1'b1, 16'h0108, 4'd0, 4'd1},
        {2'd3, 1'b1, 16'h0200, 4'd4, 4'd2},
        {2'd1, 1'b0, 16'h0300, 4'd2, 4'd1},
        {2'd1, 1'b0, 16'h0304, 4'd2, 4'd1},
        {2'd0, 1'b0, 16'h0308, 4'd1, 4'd1},
        {2'd3, 1'b0, 16'h0400, 4'd4, 4'd1},
        {2'd0, 1'b1, 16'h0800, 4'd1, 4'd2}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && !req_ready; i++) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [31:0] d);
        wait_idle();
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [31:0] cfgw(input int ws, input bit pf, input bit hold, input bit prot);
        return {25'd0, prot, hold, pf, 2'b00, ws[1:0]};
    endfunction

    // Present a request at a negedge and return at the negedge after acceptance.
    task automatic issue(input logic [31:0] a, input bit cbr, input bit cach);
        wait_idle();
        req_valid = 1'b1; req_addr = a; req_cbr = cbr; req_cach = cach;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_cbr = 1'b0; req_cach = 1'b1;
    endtask

    // Count rising edges until rsp_ready is seen.
    task automatic wait_rsp(output int lat);
        lat = 0;
        for (int i = 0; i < 20 && !rsp_ready; i++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_resolve(input bit taken);
        br_resolve = 1'b1; br_taken = taken;
        @(posedge clk);
        @(negedge clk);
        br_resolve = 1'b0; br_taken = 1'b0;
    endtask

    // Demand read with latency, data and access-count checks.
    task automatic read_chk(input string tag, input logic [31:0] a, input bit cach,
                            input int exp_lat, input int exp_acc);
        int lat, base;
        wait_idle();
        base = mem_cnt;
        issue(a, 1'b0, cach);
        wait_rsp(lat);
        check({tag, " latency"}, lat, exp_lat);
        check({tag, " data"}, rsp_data, a ^ 32'h5A5A_0000);
        wait_idle();
        check({tag, " accesses"}, mem_cnt - base, exp_acc);
    endtask

    // One branch of the scripted stream; returns nothing, counts via mem_cnt.
    task automatic branch(input bit taken, input bit hold);
        int lat;
        issue(32'h3000, 1'b0, 1'b1); wait_rsp(lat); wait_idle();
        issue(32'h4000, 1'b1, 1'b1);
        if (hold) begin
            pulse_resolve(taken); wait_rsp(lat);
        end else begin
            wait_rsp(lat); wait_idle(); pulse_resolve(taken);
        end
        issue(taken ? 32'h4004 : 32'h3004, 1'b0, 1'b1); wait_rsp(lat); wait_idle();
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat, base, off_cnt, on_cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cfg", cfg_rdata, 32'h11);
        check("R1 rsp_ready", rsp_ready, 0);
        check("R1 req_ready", req_ready, 1);

        // R2 layout and reserved bits
        cfg_write(32'hFFFF_FFFF);
        check("R2 all-ones", cfg_rdata, 32'h73);
        cfg_write(32'h0);
        check("R2 zero", cfg_rdata, 32'h0);

        // R3 hardware update alone and against a software write
        hw_ws_we = 1'b1; hw_ws_val = 2'd3; cfg_wr = 1'b1; cfg_wdata = cfgw(0, 1, 0, 0);
        @(negedge clk);
        hw_ws_we = 1'b0; cfg_wr = 1'b0;
        check("R3 hw wins", cfg_rdata, 32'h13);
        hw_ws_we = 1'b1; hw_ws_val = 2'd2;
        @(negedge clk);
        hw_ws_we = 1'b0;
        check("R3 hw alone", cfg_rdata, 32'h12);

        // R4 R6 R7 table walk
        for (int r = 0; r < NROW; r++) begin
            logic [26:0] v;
            v = ROWS[r];
            cfg_write(cfgw(int'(v[26:25]), v[24], 0, 0));
            read_chk(v[24] ? "R4/R6 row" : "R4/R7 row", {16'h0, v[23:8]}, 1'b1,
                     int'(v[7:4]), int'(v[3:0]));
        end

        // R5 wait-state change during an access
        cfg_write(cfgw(3, 0, 0, 0));
        issue(32'h1100, 1'b0, 1'b1);
        cfg_wr = 1'b1; cfg_wdata = cfgw(0, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R5 early rsp", rsp_ready, 0);
        wait_rsp(lat);
        check("R5 old latency", lat + 1, 4);
        read_chk("R5 new latency", 32'h1104, 1'b1, 1, 1);

        // R8 flush by branch target and by a miss
        cfg_write(cfgw(1, 1, 0, 0));
        read_chk("R8 fill", 32'h0500, 1'b1, 2, 2);
        base = mem_cnt;
        issue(32'h0900, 1'b1, 1'b1); wait_rsp(lat);
        check("R8 cbr latency", lat, 2);
        wait_idle();
        check("R8 cbr no prefetch", mem_cnt - base, 1);
        read_chk("R8 after cbr", 32'h0504, 1'b1, 2, 2);
        read_chk("R8 other miss", 32'h0700, 1'b1, 2, 2);
        read_chk("R8 old entry", 32'h0508, 1'b1, 2, 2);

        // R9 hold disabled: immediate fetch, resolve ignored
        cfg_write(cfgw(2, 0, 0, 0));
        base = mem_cnt;
        issue(32'h0B00, 1'b1, 1'b1); wait_rsp(lat);
        check("R9 latency", lat, 3);
        check("R9 drop", rsp_drop, 0);
        check("R9 data", rsp_data, 32'h0B00 ^ 32'h5A5A_0000);
        wait_idle();
        pulse_resolve(1'b0);
        check("R9 resolve ignored", rsp_ready, 0);
        @(negedge clk);
        check("R9 resolve ignored ready", req_ready, 1);
        check("R9 accesses", mem_cnt - base, 1);

        // R10 hold enabled, taken then not taken
        cfg_write(cfgw(1, 0, 1, 0));
        base = mem_cnt;
        issue(32'h0C00, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        check("R10 held no access", mem_cnt - base, 0);
        check("R10 held no rsp", rsp_ready, 0);
        check("R10 held busy", req_ready, 0);
        pulse_resolve(1'b1); wait_rsp(lat);
        check("R10 taken latency", lat, 2);
        check("R10 taken drop", rsp_drop, 0);
        check("R10 taken data", rsp_data, 32'h0C00 ^ 32'h5A5A_0000);
        wait_idle();
        check("R10 taken accesses", mem_cnt - base, 1);
        base = mem_cnt;
        issue(32'h0D00, 1'b1, 1'b1);
        @(negedge clk);
        pulse_resolve(1'b0); wait_rsp(lat);
        check("R10 not-taken latency", lat, 0);
        check("R10 not-taken drop", rsp_drop, 1);
        wait_idle();
        check("R10 not-taken accesses", mem_cnt - base, 0);

        // R11 scripted branch stream T,N,N,T,N with and without hold
        cfg_write(cfgw(0, 0, 0, 0));
        base = mem_cnt;
        branch(1, 0); branch(0, 0); branch(0, 0); branch(1, 0); branch(0, 0);
        off_cnt = mem_cnt - base;
        cfg_write(cfgw(0, 0, 1, 0));
        base = mem_cnt;
        branch(1, 1); branch(0, 1); branch(0, 1); branch(1, 1); branch(0, 1);
        on_cnt = mem_cnt - base;
        check("R11 without hold", off_cnt, 15);
        check("R11 saving", on_cnt, off_cnt - 3);

        // R12 cacheable attribute mode
        cfg_write(cfgw(1, 1, 0, 1));
        read_chk("R12 noncach no pf", 32'h0600, 1'b0, 2, 1);
        read_chk("R12 cach pf", 32'h0600, 1'b1, 2, 2);
        read_chk("R12 noncach no hit", 32'h0604, 1'b0, 2, 1);
        cfg_write(cfgw(1, 1, 0, 0));
        read_chk("R12 ignored pf", 32'h0A00, 1'b0, 2, 2);
        read_chk("R12 ignored hit", 32'h0A04, 1'b0, 0, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule